// File: doc/BRIEF.md
# Coincident-Current Core Store Controller

This block sequences one access to an 18-plane coincident-current magnetic core store holding 32K words. Each word carries 16 data bits and two odd parity bits, one for each byte. Reading a core destroys its contents. Every access therefore runs a drive toward 0, a sense strobe, and a drive toward 1. During the drive toward 1, per-plane inhibits keep the cores that should hold 0 from flipping.

For a read, the sensed word is restored unchanged. Its data is returned and its parity is checked. For a write, the sensed word is thrown away, and the new data with freshly generated parity is stored. The 15-bit address is split into fields:

- an X gate line, one of 16;
- an X driver, one of 8;
- a Y line, one of 128;
- a Y current polarity bit, which picks one of the two cores that share an X drive line.

Each plane's sense output arrives as four quarter-section signals, and these are ORed together. The analog drivers and preamplifiers sit outside the block.

Top module: `core_mem_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o, strobe_o, rd_phase_o, wr_phase_o, perr_o, rdata_o, inhibit_o and all X/Y select lines are 0.
- R2: During a drive phase, x_gate_o is one-hot at addr bits 3:0, x_drv_o is one-hot at addr bits 6:4, y_sel_o is one-hot at addr bits 13:7, and y_pol_o equals addr bit 14. X and Y are always asserted together. All select lines are 0 outside the drive phases.
- R3: A request taken while idle gives this sequence: 3 cycles of rd_phase_o, 1 cycle of strobe_o, 3 cycles of wr_phase_o, then 1 cycle of done_o. busy_o is high from the cycle after acceptance through the done cycle.
- R4: The bit for plane p is the OR of sense_i[4p+3:4p]. The sense inputs are sampled only during the strobe cycle.
- R5: The restore phase of a read drives inhibit_o[p] high exactly for the planes whose captured bit is 0, and it addresses the same core that was read.
- R6: A write drives inhibit_o = ~{par_hi, par_lo, wdata}. Here par_lo (plane 16) is odd parity over data bits 7:0, and par_hi (plane 17) is odd parity over data bits 15:8.
- R7: After a read, rdata_o holds the captured data bits 15:0 from the done cycle onward. perr_o is 1 if either byte with its parity bit has an even number of ones, and 0 otherwise. Even on a parity error, the restore writes back the captured word unchanged.
- R8: A write request leaves rdata_o and perr_o unchanged.
- R9: Requests that arrive while busy_o is high are ignored. The address and kind of the access in flight do not change.
- R10: inhibit_o is nonzero only during wr_phase_o. rd_phase_o and wr_phase_o are never high together. strobe_o is high only between the two drive phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken while idle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 15 | Word address: gate[3:0], driver[6:4], Y[13:7], polarity[14] |
| wdata_i | input | 16 | Write data |
| sense_i | input | 72 | Quarter-section sense outputs, four for each plane |
| busy_o | output | 1 | Access in progress |
| x_gate_o | output | 16 | X gate line select |
| x_drv_o | output | 8 | X driver select |
| y_sel_o | output | 128 | One-hot Y line select |
| y_pol_o | output | 1 | Y current polarity |
| rd_phase_o | output | 1 | Drive toward 0 (read half) |
| wr_phase_o | output | 1 | Drive toward 1 (write half) |
| inhibit_o | output | 18 | Per-plane inhibit enables |
| strobe_o | output | 1 | Sense strobe |
| done_o | output | 1 | Access complete, one cycle |
| rdata_o | output | 16 | Last read data |
| perr_o | output | 1 | Parity error on the last read |

## Verification
Read tests use several stored words: a mixed data pattern, an all-zero data word, a single set bit, and a word with a corrupted parity bit. The sense pulses are placed in a single rotating quarter section in some tests and in all four sections in others. This shows whether every section really reaches the plane bit. Outside the strobe, the sense lines are held at all ones, so capture at the wrong cycle shows up as a changed read value.

Write tests use all-ones and all-zeros data. These show whether the inhibits follow the new word, not the sensed one, and whether read status is left alone. Addresses at both extremes and one with a distinct value in every field show whether the fields are split correctly. A request held high during a whole access shows whether new requests are refused while busy.

// File: rtl/core_mem_pkg.sv
package core_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_STB,
    ST_WR,
    ST_DONE
  } cyc_st_e;
endpackage

// File: rtl/core_xy_decode.sv
module core_xy_decode #(
  parameter int GATE_W = 4,
  parameter int DRV_W  = 3,
  parameter int Y_W    = 7
) (
  input  logic                          en_i,
  input  logic [GATE_W+DRV_W+Y_W-1:0]   addr_i,
  output logic [2**GATE_W-1:0]          gate_o,
  output logic [2**DRV_W-1:0]           drv_o,
  output logic [2**Y_W-1:0]             y_o
);
  localparam int GN = 2**GATE_W;
  localparam int DN = 2**DRV_W;
  localparam int YN = 2**Y_W;

  logic [GATE_W-1:0] g_idx;
  logic [DRV_W-1:0]  d_idx;
  logic [Y_W-1:0]    y_idx;

  assign g_idx = addr_i[GATE_W-1:0];
  assign d_idx = addr_i[GATE_W +: DRV_W];
  assign y_idx = addr_i[GATE_W+DRV_W +: Y_W];

  // X and Y share one enable so a lone half-current never appears
  assign gate_o = en_i ? (GN'(1) << g_idx) : '0;
  assign drv_o  = en_i ? (DN'(1) << d_idx) : '0;
  assign y_o    = en_i ? (YN'(1) << y_idx) : '0;
endmodule

// File: rtl/core_parity_gen.sv
module core_parity_gen #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0]        data_i,
  output logic [DATA_W/BYTE_W-1:0] par_o
);
  for (genvar g = 0; g < DATA_W/BYTE_W; g++) begin : g_byte
    assign par_o[g] = ~(^data_i[g*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/core_sense_merge.sv
module core_sense_merge #(
  parameter int WORD_W = 18,
  parameter int SECT   = 4
) (
  input  logic [WORD_W*SECT-1:0] sense_i,
  output logic [WORD_W-1:0]      bit_o
);
  for (genvar p = 0; p < WORD_W; p++) begin : g_plane
    assign bit_o[p] = |sense_i[p*SECT +: SECT];
  end
endmodule

// File: rtl/core_mem_ctrl.sv
module core_mem_ctrl #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int SECT   = 4,
  parameter int GATE_W = 4,
  parameter int DRV_W  = 3,
  parameter int Y_W    = 7,
  parameter int RD_CYC = 3,
  parameter int WR_CYC = 3
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    req_i,
  input  logic                                    we_i,
  input  logic [GATE_W+DRV_W+Y_W:0]               addr_i,
  input  logic [DATA_W-1:0]                       wdata_i,
  input  logic [(DATA_W+DATA_W/BYTE_W)*SECT-1:0]  sense_i,
  output logic                                    busy_o,
  output logic [2**GATE_W-1:0]                    x_gate_o,
  output logic [2**DRV_W-1:0]                     x_drv_o,
  output logic [2**Y_W-1:0]                       y_sel_o,
  output logic                                    y_pol_o,
  output logic                                    rd_phase_o,
  output logic                                    wr_phase_o,
  output logic [DATA_W+DATA_W/BYTE_W-1:0]         inhibit_o,
  output logic                                    strobe_o,
  output logic                                    done_o,
  output logic [DATA_W-1:0]                       rdata_o,
  output logic                                    perr_o
);
  import core_mem_pkg::*;

  localparam int NPAR   = DATA_W/BYTE_W;
  localparam int WORD_W = DATA_W + NPAR;
  localparam int XA_W   = GATE_W + DRV_W + Y_W;
  localparam int MAXC   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  cyc_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [XA_W:0]     addr_q;
  logic              we_q;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] rdata_q;
  logic              perr_q;

  logic [NPAR-1:0]   par_new;
  logic [NPAR-1:0]   par_sensed;
  logic [WORD_W-1:0] sensed;
  logic              drive_en;

  core_parity_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_par_wr (
    .data_i (wdata_i),
    .par_o  (par_new)
  );

  core_sense_merge #(.WORD_W(WORD_W), .SECT(SECT)) u_sense (
    .sense_i (sense_i),
    .bit_o   (sensed)
  );

  core_parity_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_par_rd (
    .data_i (sensed[DATA_W-1:0]),
    .par_o  (par_sensed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      word_q  <= '0;
      rdata_q <= '0;
      perr_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          st_q   <= ST_RD;
          cnt_q  <= '0;
          addr_q <= addr_i;
          we_q   <= we_i;
          if (we_i) word_q <= {par_new, wdata_i};
        end
        ST_RD: begin
          if (cnt_q == CNT_W'(RD_CYC-1)) begin
            st_q  <= ST_STB;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STB: begin
          st_q <= ST_WR;
          // sensed word is the restore word for reads, discarded for writes
          if (!we_q) begin
            word_q  <= sensed;
            rdata_q <= sensed[DATA_W-1:0];
            perr_q  <= |(par_sensed ^ sensed[WORD_W-1:DATA_W]);
          end
        end
        ST_WR: begin
          if (cnt_q == CNT_W'(WR_CYC-1)) begin
            st_q  <= ST_DONE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_phase_o = (st_q == ST_RD);
  assign wr_phase_o = (st_q == ST_WR);
  assign strobe_o   = (st_q == ST_STB);
  assign done_o     = (st_q == ST_DONE);
  assign busy_o     = (st_q != ST_IDLE);
  assign drive_en   = rd_phase_o | wr_phase_o;

  core_xy_decode #(.GATE_W(GATE_W), .DRV_W(DRV_W), .Y_W(Y_W)) u_dec (
    .en_i   (drive_en),
    .addr_i (addr_q[XA_W-1:0]),
    .gate_o (x_gate_o),
    .drv_o  (x_drv_o),
    .y_o    (y_sel_o)
  );

  assign y_pol_o   = addr_q[XA_W];
  assign inhibit_o = wr_phase_o ? ~word_q : '0;
  assign rdata_o   = rdata_q;
  assign perr_o    = perr_q;
endmodule

// File: rtl/core_mem_ctrl_chk.sv
module core_mem_ctrl_chk #(
  parameter int GATE_W = 4,
  parameter int DRV_W  = 3,
  parameter int Y_W    = 7,
  parameter int WORD_W = 18
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 busy_o,
  input logic [2**GATE_W-1:0] x_gate_o,
  input logic [2**DRV_W-1:0]  x_drv_o,
  input logic [2**Y_W-1:0]    y_sel_o,
  input logic                 y_pol_o,
  input logic                 rd_phase_o,
  input logic                 wr_phase_o,
  input logic [WORD_W-1:0]    inhibit_o,
  input logic                 strobe_o,
  input logic                 done_o
);
  assert_sel_both_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_phase_o || wr_phase_o) |->
      ($countones(x_gate_o) == 1 && $countones(x_drv_o) == 1 && $countones(y_sel_o) == 1));

  assert_sel_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_phase_o || wr_phase_o) |-> (x_gate_o == '0 && x_drv_o == '0 && y_sel_o == '0));

  assert_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> (busy_o && rd_phase_o));

  assert_strobe_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> wr_phase_o);

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_restore_same_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> (y_sel_o == $past(y_sel_o, 2) && x_gate_o == $past(x_gate_o, 2)
                  && x_drv_o == $past(x_drv_o, 2)));

  assert_pol_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(y_pol_o));

  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_phase_o && $past(rd_phase_o)) |-> ($stable(y_sel_o) && $stable(x_gate_o) && $stable(x_drv_o)));

  assert_phase_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_phase_o && wr_phase_o));

  assert_inhibit_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_o != '0) |-> wr_phase_o);

  assert_strobe_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $countones({rd_phase_o, wr_phase_o, done_o}) == 0);
endmodule

bind core_mem_ctrl core_mem_ctrl_chk #(
  .GATE_W (GATE_W),
  .DRV_W  (DRV_W),
  .Y_W    (Y_W),
  .WORD_W (DATA_W + DATA_W/BYTE_W)
) u_chk (.*);

// File: tb/core_mem_ctrl_test.sv
module core_mem_ctrl_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0;
  logic         we_i = 1'b0;
  logic [14:0]  addr_i = '0;
  logic [15:0]  wdata_i = '0;
  logic [71:0]  sense_i;
  logic [71:0]  sense_pat = '0;
  logic         busy_o, y_pol_o, rd_phase_o, wr_phase_o, strobe_o, done_o, perr_o;
  logic [15:0]  x_gate_o;
  logic [7:0]   x_drv_o;
  logic [127:0] y_sel_o;
  logic [17:0]  inhibit_o;
  logic [15:0]  rdata_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] last_rdata = '0;
  logic        last_perr = 1'b0;

  core_mem_ctrl uut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .sense_i,
    .busy_o, .x_gate_o, .x_drv_o, .y_sel_o, .y_pol_o, .rd_phase_o,
    .wr_phase_o, .inhibit_o, .strobe_o, .done_o, .rdata_o, .perr_o
  );

  always #10 clk_i = ~clk_i;

  // junk outside the strobe exposes sampling at the wrong cycle (R4)
  always_comb sense_i = strobe_o ? sense_pat : '1;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [17:0] mkword(input logic [15:0] d);
    return {~(^d[15:8]), ~(^d[7:0]), d};
  endfunction

  function automatic logic [71:0] spread(input logic [17:0] w, input bit all4);
    logic [71:0] s = '0;
    for (int p = 0; p < 18; p++)
      if (w[p]) begin
        if (all4) s[p*4 +: 4] = 4'hF;
        else      s[p*4 + (p % 4)] = 1'b1;
      end
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input string scn, input bit we, input logic [14:0] a,
                           input logic [15:0] d, input logic [17:0] stored,
                           input bit all4, input bit interfere,
                           input logic [15:0] exp_rd, input bit exp_pe);
    logic [17:0]  exp_word = we ? mkword(d) : stored;
    logic [15:0]  eg = 16'h1 << a[3:0];
    logic [7:0]   ed = 8'h1 << a[6:4];
    logic [127:0] ey = 128'h1 << a[13:7];
    @(negedge clk_i);
    check(!busy_o, {scn, " R3 idle before request"}, busy_o, 0);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; sense_pat = spread(stored, all4);
    for (int c = 1; c <= 9; c++) begin
      @(negedge clk_i);
      if (c >= 1 && c <= 3) begin
        check(rd_phase_o && !wr_phase_o && busy_o && inhibit_o == '0,
              {scn, " R3 read phase"}, {rd_phase_o, wr_phase_o, busy_o, inhibit_o}, {3'b101, 18'h0});
        check(x_gate_o == eg && x_drv_o == ed && y_sel_o == ey && y_pol_o == a[14],
              {scn, " R2 read select"}, {x_gate_o, x_drv_o, y_pol_o}, {eg, ed, a[14]});
      end else if (c == 4) begin
        check(strobe_o && !rd_phase_o && !wr_phase_o && y_sel_o == '0 && x_gate_o == '0,
              {scn, " R10 strobe gap"}, {strobe_o, rd_phase_o, wr_phase_o}, 3'b100);
      end else if (c <= 7) begin
        check(wr_phase_o && !rd_phase_o && busy_o, {scn, " R3 write phase"},
              {wr_phase_o, rd_phase_o}, 2'b10);
        check(inhibit_o == ~exp_word, {scn, we ? " R6 write inhibits" : " R5 restore inhibits"},
              inhibit_o, ~exp_word);
        check(x_gate_o == eg && x_drv_o == ed && y_sel_o == ey && y_pol_o == a[14],
              {scn, " R5 restore select"}, {x_gate_o, x_drv_o, y_pol_o}, {eg, ed, a[14]});
      end else if (c == 8) begin
        check(done_o && busy_o, {scn, " R3 done"}, {done_o, busy_o}, 2'b11);
        check(rdata_o == exp_rd && perr_o == exp_pe,
              {scn, we ? " R8 status kept" : " R7 read data"}, {perr_o, rdata_o}, {exp_pe, exp_rd});
      end else begin
        check(!busy_o && !done_o, {scn, " R3 back to idle"}, {busy_o, done_o}, 2'b00);
      end
      if (!interfere && c == 1) req_i = 1'b0;
      if (interfere && c == 1) begin
        addr_i = ~a; we_i = ~we; wdata_i = ~d;
      end
      if (interfere && c == 8) req_i = 1'b0;
    end
    if (!we) begin
      last_rdata = exp_rd;
      last_perr  = exp_pe;
    end
  endtask

  task automatic test_reset;
    #5;
    check(!busy_o && !done_o && !strobe_o && !rd_phase_o && !wr_phase_o && !perr_o
          && rdata_o == '0 && inhibit_o == '0 && x_gate_o == '0 && x_drv_o == '0 && y_sel_o == '0,
          "R1 outputs in reset", {busy_o, done_o, strobe_o, perr_o, rdata_o}, 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !strobe_o && inhibit_o == '0 && y_sel_o == '0 && rdata_o == '0,
          "R1 outputs after release", {busy_o, done_o, strobe_o, rdata_o}, 0);
  endtask

  task automatic test_read_clean;   // R4 R5 R7
    run_cycle("read_clean", 1'b0, 15'h0000, 16'h0, mkword(16'hA5C3), 1'b0, 1'b0, 16'hA5C3, 1'b0);
    run_cycle("read_top", 1'b0, 15'h7FFF, 16'h0, mkword(16'h0001), 1'b1, 1'b0, 16'h0001, 1'b0);
    run_cycle("read_zero", 1'b0, 15'h1234, 16'h0, mkword(16'h0000), 1'b0, 1'b0, 16'h0000, 1'b0);
  endtask

  task automatic test_read_perr;    // R7: flagged, restored unchanged, then cleared
    run_cycle("read_perr", 1'b0, 15'h0A0A, 16'h0, mkword(16'h1234) ^ 18'h10000, 1'b1, 1'b0,
              16'h1234, 1'b1);
    run_cycle("read_perr_hi", 1'b0, 15'h0A0B, 16'h0, mkword(16'h8001) ^ 18'h20000, 1'b0, 1'b0,
              16'h8001, 1'b1);
    run_cycle("read_after_perr", 1'b0, 15'h0A0C, 16'h0, mkword(16'h00FF), 1'b0, 1'b0,
              16'h00FF, 1'b0);
  endtask

  task automatic test_write;        // R6 R8
    run_cycle("write_ones", 1'b1, 15'h2345, 16'hFFFF, 18'h15555, 1'b1, 1'b0, last_rdata, last_perr);
    run_cycle("write_zero", 1'b1, 15'h5432, 16'h0000, 18'h3FFFF, 1'b0, 1'b0, last_rdata, last_perr);
  endtask

  task automatic test_busy_hold;    // R9: request held high during a whole access
    run_cycle("R9 busy_hold", 1'b0, 15'h3C21, 16'h0, mkword(16'h5AA5), 1'b0, 1'b1, 16'h5AA5, 1'b0);
  endtask

  task automatic test_addr_map;     // R2: distinct value in every field
    run_cycle("addr_map", 1'b0, {1'b1, 7'h55, 3'd5, 4'd9}, 16'h0, mkword(16'hC001), 1'b1, 1'b0,
              16'hC001, 1'b0);
  endtask

  initial begin
    test_reset();
    test_read_clean();
    test_read_perr();
    test_write();
    test_busy_hold();
    test_addr_map();
    @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule